// File: doc/BRIEF.md
# Toggle-Handshake Nibble Link

This block carries bytes in both directions between the FPGA fabric and a companion microcontroller over eight pins. The pins are split into two independent one-way channels of four wires each. One channel sends and one receives. Each channel has a data-valid toggle wire, an acknowledge toggle wire that the receiving side drives back, and two data wires. A transition on the valid wire means that a new 2-bit slice is present. A transition on the acknowledge wire means that the slice was taken. There are no strobe pulses and no shared clock, so the far side can poll the wires as slowly as it likes.

On the fabric side, the block accepts bytes through a valid/ready port. It cuts each byte into four 2-bit slices, most significant slice first, and sends them with the toggle handshake. In the other direction it synchronises the incoming wires into its clock domain and acknowledges each slice. It rebuilds the byte and presents it with a one-cycle valid pulse. The two directions share nothing except the clock and reset.

Top module: `duplex_toggle_link`

## Requirements
- R1: While reset is high and just after it falls, `link_tx_clk`, `link_tx_dat` and `link_rx_ack` are 0, `rx_valid` is 0 and `tx_ready` is 1 (with `link_tx_ack` low).
- R2: An accepted byte leaves as exactly four slices on `link_tx_dat`, bits [7:6] first and bits [1:0] last, with one transition of `link_tx_clk` per slice.
- R3: While `link_tx_clk` differs from the acknowledge level seen from `link_tx_ack`, neither `link_tx_dat` nor `link_tx_clk` changes.
- R4: `tx_ready` falls in the cycle after a byte is accepted. It stays low until the far side has acknowledged the fourth slice. A `tx_valid` asserted while `tx_ready` is low sends nothing.
- R5: `link_tx_dat` holds its new slice for at least one clock cycle before `link_tx_clk` toggles.
- R6: `link_rx_ack` toggles exactly once for each transition of `link_rx_clk`, and only after that transition. After each toggle its level equals `link_rx_clk`.
- R7: After every fourth received slice, `rx_valid` is high for exactly one cycle. `rx_data` then holds the byte, with the first slice in bits [7:6].
- R8: The link tolerates arbitrarily long gaps between toggles on either side, and both directions run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Byte offered for sending |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Link can accept a byte |
| rx_valid | output | 1 | One-cycle pulse: received byte present |
| rx_data | output | 8 | Received byte |
| link_tx_clk | output | 1 | Outgoing data-valid toggle |
| link_tx_dat | output | 2 | Outgoing slice |
| link_tx_ack | input | 1 | Acknowledge toggle from the far side (asynchronous) |
| link_rx_clk | input | 1 | Incoming data-valid toggle (asynchronous) |
| link_rx_dat | input | 2 | Incoming slice (asynchronous) |
| link_rx_ack | output | 1 | Acknowledge toggle back to the far side |

## Verification
The hardest cases to produce are the ones where the far side is slow. A slice can stay unacknowledged for dozens of cycles while the fabric keeps offering bytes, and the two directions can be mid-byte at once. A behavioural far-end model reaches these cases. It holds each acknowledge for a random or deliberately long time and watches the data wires for any change during that wait. Meanwhile the bench floods `tx_valid` during a busy period. In the concurrent run, the bench sends bytes in both directions with independent random delays and compares the full sequences in order.

// File: rtl/tlink_pkg.sv
package tlink_pkg;
  // transmit sequencer states
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_SETUP  = 2'd1,
    TX_STROBE = 2'd2
  } tx_state_e;
endpackage

// File: rtl/tlink_sync.sv
module tlink_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tlink_tx.sv
module tlink_tx
  import tlink_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SLICE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [BYTE_W-1:0]  in_data,
  output logic               in_ready,
  output logic               pin_clk,
  output logic [SLICE_W-1:0] pin_dat,
  input  logic               pin_ack
);
  localparam int SLICES = BYTE_W / SLICE_W;
  localparam int CNT_W  = $clog2(SLICES + 1);

  logic              ack_s;
  logic              clk_q;
  logic [SLICE_W-1:0] dat_q;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  left;
  tx_state_e         st;
  logic              ack_match;

  tlink_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(clk), .rst(rst), .d(pin_ack), .q(ack_s)
  );

  assign ack_match = (ack_s == clk_q);
  assign in_ready  = (st == TX_IDLE) && ack_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= TX_IDLE;
      clk_q <= 1'b0;
      dat_q <= '0;
      shreg <= '0;
      left  <= '0;
    end else begin
      case (st)
        TX_IDLE: begin
          if (in_valid && in_ready) begin
            shreg <= in_data;
            left  <= CNT_W'(SLICES);
            st    <= TX_SETUP;
          end
        end
        TX_SETUP: begin
          // previous slice consumed: present the next one
          if (ack_match) begin
            dat_q <= shreg[BYTE_W-1 -: SLICE_W];
            shreg <= shreg << SLICE_W;
            left  <= left - CNT_W'(1);
            st    <= TX_STROBE;
          end
        end
        TX_STROBE: begin
          clk_q <= ~clk_q;
          st    <= (left == '0) ? TX_IDLE : TX_SETUP;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign pin_clk = clk_q;
  assign pin_dat = dat_q;

  assert_hold_unacked_R3: assert property (@(posedge clk) disable iff (rst)
    (clk_q != ack_s) |=> ($stable(dat_q) && $stable(clk_q)));

  assert_data_setup_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(clk_q) |-> $stable(dat_q));

  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/tlink_rx.sv
module tlink_rx #(
  parameter int BYTE_W      = 8,
  parameter int SLICE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_clk,
  input  logic [SLICE_W-1:0] pin_dat,
  output logic               pin_ack,
  output logic               out_valid,
  output logic [BYTE_W-1:0]  out_data
);
  localparam int SLICES = BYTE_W / SLICE_W;
  localparam int CNT_W  = $clog2(SLICES + 1);

  logic               clk_s;
  logic [SLICE_W-1:0] dat_s;
  logic               ack_q;
  logic [BYTE_W-1:0]  shreg;
  logic [BYTE_W-1:0]  assembled;
  logic [CNT_W-1:0]   cnt;
  logic               fresh;

  // toggle and data share one synchroniser so their latency is equal
  tlink_sync #(.WIDTH(1 + SLICE_W), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst(rst), .d({pin_clk, pin_dat}), .q({clk_s, dat_s})
  );

  assign fresh     = (clk_s != ack_q);
  assign assembled = {shreg[BYTE_W-SLICE_W-1:0], dat_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q     <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (fresh) begin
        ack_q <= ~ack_q;
        shreg <= assembled;
        if (cnt == CNT_W'(SLICES - 1)) begin
          cnt       <= '0;
          out_valid <= 1'b1;
          out_data  <= assembled;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign pin_ack = ack_q;

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_single_ack_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(ack_q) |=> $stable(ack_q));
endmodule

// File: rtl/duplex_toggle_link.sv
module duplex_toggle_link #(
  parameter int BYTE_W      = 8,
  parameter int SLICE_W     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_valid,
  input  logic [BYTE_W-1:0]  tx_data,
  output logic               tx_ready,
  output logic               rx_valid,
  output logic [BYTE_W-1:0]  rx_data,
  output logic               link_tx_clk,
  output logic [SLICE_W-1:0] link_tx_dat,
  input  logic               link_tx_ack,
  input  logic               link_rx_clk,
  input  logic [SLICE_W-1:0] link_rx_dat,
  output logic               link_rx_ack
);
  tlink_tx #(.BYTE_W(BYTE_W), .SLICE_W(SLICE_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst(rst),
    .in_valid(tx_valid), .in_data(tx_data), .in_ready(tx_ready),
    .pin_clk(link_tx_clk), .pin_dat(link_tx_dat), .pin_ack(link_tx_ack)
  );

  tlink_rx #(.BYTE_W(BYTE_W), .SLICE_W(SLICE_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst),
    .pin_clk(link_rx_clk), .pin_dat(link_rx_dat), .pin_ack(link_rx_ack),
    .out_valid(rx_valid), .out_data(rx_data)
  );

  assert_ack_tracks_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_rx_ack) |-> (link_rx_ack == link_rx_clk));
endmodule

// File: tb/duplex_toggle_link_test.sv
module duplex_toggle_link_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst = 1'b1;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready, rx_valid, link_tx_clk, link_rx_ack;
  logic [7:0] rx_data;
  logic [1:0] link_tx_dat;
  logic       fe_ack = 1'b0;
  logic       fe_clk = 1'b0;
  logic [1:0] fe_dat = 2'b00;

  duplex_toggle_link uut (
    .clk(clk), .rst(rst),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .link_tx_clk(link_tx_clk), .link_tx_dat(link_tx_dat), .link_tx_ack(fe_ack),
    .link_rx_clk(fe_clk), .link_rx_dat(fe_dat), .link_rx_ack(link_rx_ack)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // far-end receiver of the outgoing channel
  int         ack_dly_min = 0;
  int         ack_dly_max = 3;
  logic [7:0] fe_got[$];
  logic [1:0] fe_slices[$];
  int         fe_setup_bad = 0;
  int         fe_hold_bad  = 0;

  initial begin
    logic [7:0] acc;
    logic [1:0] s;
    logic [1:0] prev_dat;
    int n;
    int d;
    acc = 8'h00; prev_dat = 2'b00; n = 0;
    forever begin
      @(negedge clk);
      if (!rst && (link_tx_clk != fe_ack)) begin
        s = link_tx_dat;
        if (s != prev_dat) fe_setup_bad++;
        d = $urandom_range(ack_dly_max, ack_dly_min);
        repeat (d) begin
          @(negedge clk);
          if (link_tx_dat != s || link_tx_clk == fe_ack) fe_hold_bad++;
        end
        fe_slices.push_back(s);
        acc = {acc[5:0], s};
        n++;
        if (n == 4) begin
          fe_got.push_back(acc);
          n = 0;
        end
        fe_ack = ~fe_ack;
      end
      prev_dat = link_tx_dat;
    end
  end

  // fabric-side receive monitor
  logic [7:0] dut_got[$];
  int   rx_double = 0;
  int   rx_ack_toggles = 0;
  logic prev_v = 1'b0;
  logic prev_ack = 1'b0;
  always @(negedge clk) begin
    if (rx_valid) dut_got.push_back(rx_data);
    if (rx_valid && prev_v) rx_double++;
    if (link_rx_ack != prev_ack) rx_ack_toggles++;
    prev_v   = rx_valid;
    prev_ack = link_rx_ack;
  end

  task automatic fe_send(input logic [7:0] b, input int gap);
    int t;
    for (int i = 3; i >= 0; i--) begin
      fe_dat = b[2*i +: 2];
      @(negedge clk);
      fe_clk = ~fe_clk;
      t = 0;
      while (link_rx_ack != fe_clk && t < 5000) begin
        @(negedge clk);
        t++;
      end
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic dut_send(input logic [7:0] b);
    int t;
    tx_data  = b;
    tx_valid = 1'b1;
    t = 0;
    while (!tx_ready && t < 20000) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    tx_valid = 1'b0;
    check(!tx_ready, "R4", "tx_ready after accept", tx_ready, 0);
  endtask

  task automatic wait_fe(input int n);
    int t = 0;
    while (fe_got.size() < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic wait_dut(input int n);
    int t = 0;
    while (dut_got.size() < n && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
  endtask

  task automatic clear_logs();
    fe_got.delete();
    fe_slices.delete();
    dut_got.delete();
    fe_setup_bad = 0;
    fe_hold_bad = 0;
    rx_double = 0;
    rx_ack_toggles = 0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(link_tx_clk == 1'b0, "R1", "link_tx_clk in reset", link_tx_clk, 0);
    check(link_tx_dat == 2'b00, "R1", "link_tx_dat in reset", link_tx_dat, 0);
    check(link_rx_ack == 1'b0, "R1", "link_rx_ack in reset", link_rx_ack, 0);
    check(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
  endtask

  task automatic t_tx_order();
    logic [1:0] exp_s[4];
    clear_logs();
    ack_dly_min = 0; ack_dly_max = 3;
    dut_send(8'hB4);
    wait_fe(1);
    check(fe_got.size() == 1 && fe_got[0] == 8'hB4, "R2", "tx byte",
          fe_got.size() ? int'(fe_got[0]) : -1, 8'hB4);
    exp_s = '{2'd2, 2'd3, 2'd1, 2'd0};
    check(fe_slices.size() == 4, "R2", "slice count", fe_slices.size(), 4);
    for (int i = 0; i < 4 && i < fe_slices.size(); i++)
      check(fe_slices[i] == exp_s[i], "R2", "slice order", fe_slices[i], exp_s[i]);
    check(fe_setup_bad == 0, "R5", "data setup before toggle", fe_setup_bad, 0);
  endtask

  task automatic t_tx_busy();
    int t;
    clear_logs();
    ack_dly_min = 20; ack_dly_max = 30;
    dut_send(8'h5A);
    tx_data = 8'hFF;
    tx_valid = 1'b1;
    repeat (10) begin
      @(negedge clk);
      check(!tx_ready, "R4", "ready low while busy", tx_ready, 0);
    end
    tx_valid = 1'b0;
    t = 0;
    while (!tx_ready && t < 20000) begin
      @(negedge clk);
      t++;
    end
    check(fe_got.size() == 1, "R4", "final ack before ready", fe_got.size(), 1);
    repeat (60) @(negedge clk);
    check(fe_got.size() == 1 && fe_got[0] == 8'h5A, "R4", "ignored valid sent nothing",
          fe_got.size(), 1);
  endtask

  task automatic t_tx_hold();
    clear_logs();
    ack_dly_min = 40; ack_dly_max = 60;
    dut_send(8'hC3);
    wait_fe(1);
    check(fe_hold_bad == 0, "R3", "pins stable while unacked", fe_hold_bad, 0);
    check(fe_got.size() == 1 && fe_got[0] == 8'hC3, "R3", "byte after slow acks",
          fe_got.size() ? int'(fe_got[0]) : -1, 8'hC3);
  endtask

  task automatic t_rx_single();
    clear_logs();
    fe_send(8'h96, 3);
    wait_dut(1);
    check(dut_got.size() == 1, "R7", "rx byte count", dut_got.size(), 1);
    check(dut_got.size() > 0 && dut_got[0] == 8'h96, "R7", "rx byte value",
          dut_got.size() ? int'(dut_got[0]) : -1, 8'h96);
    check(rx_double == 0, "R7", "rx_valid one cycle", rx_double, 0);
    check(rx_ack_toggles == 4, "R6", "ack toggles per byte", rx_ack_toggles, 4);
    check(link_rx_ack == fe_clk, "R6", "ack level matches", link_rx_ack, fe_clk);
  endtask

  task automatic t_long_gaps();
    clear_logs();
    fe_send(8'h0F, 600);
    wait_dut(1);
    check(dut_got.size() == 1 && dut_got[0] == 8'h0F, "R8", "rx with long gaps",
          dut_got.size() ? int'(dut_got[0]) : -1, 8'h0F);
    ack_dly_min = 400; ack_dly_max = 500;
    dut_send(8'hE1);
    wait_fe(1);
    check(fe_got.size() == 1 && fe_got[0] == 8'hE1, "R8", "tx with long ack delays",
          fe_got.size() ? int'(fe_got[0]) : -1, 8'hE1);
  endtask

  task automatic t_duplex();
    logic [7:0] txp[6];
    logic [7:0] rxp[6];
    clear_logs();
    ack_dly_min = 0; ack_dly_max = 8;
    for (int i = 0; i < 6; i++) begin
      txp[i] = 8'(i * 37 + 11);
      rxp[i] = 8'(i * 91 + 200);
    end
    fork
      begin
        for (int i = 0; i < 6; i++) dut_send(txp[i]);
      end
      begin
        for (int i = 0; i < 6; i++) fe_send(rxp[i], $urandom_range(6, 0));
      end
    join
    wait_fe(6);
    wait_dut(6);
    check(fe_got.size() == 6, "R8", "duplex tx count", fe_got.size(), 6);
    check(dut_got.size() == 6, "R8", "duplex rx count", dut_got.size(), 6);
    for (int i = 0; i < 6; i++) begin
      if (i < fe_got.size())
        check(fe_got[i] == txp[i], "R8", "duplex tx byte", fe_got[i], txp[i]);
      if (i < dut_got.size())
        check(dut_got[i] == rxp[i], "R8", "duplex rx byte", dut_got[i], rxp[i]);
    end
    check(fe_setup_bad == 0, "R5", "duplex data setup", fe_setup_bad, 0);
  endtask

  initial begin
    t_reset();
    t_tx_order();
    t_tx_busy();
    t_tx_hold();
    t_rx_single();
    t_long_gaps();
    t_duplex();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule